// File: doc/BRIEF.md
# Modular Exponentiation Sequencer

This block is the control engine for a modular exponentiation. It owns no operand data. It steers an external Montgomery multiplier through a start/done handshake. For each multiplication it issues, it names the source of the first operand, the source of the second operand and the register that receives the product. The datapath holds five values: a base, a precomputed constant R² mod M, an accumulator, a running square and a result. The multiplier's operand roles are fixed, so the sequencer always places each value in a defined slot.

The exponent is scanned from its least significant bit upward, with a square register kept beside the accumulator. A command carries one 64-bit exponent word. A fresh command first moves the base into the Montgomery domain and sets the accumulator to the Montgomery form of one. A continue command skips that step and resumes with the accumulator and square left by the previous word, so exponents of any multiple of 64 bits can be processed as a chain of words, lowest word first. A last-word flag marks the final word. On that word the sequencer stops after the highest set bit and issues one multiplication that takes the accumulator out of the Montgomery domain into the result register.

Top module: `modexp_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mm_start` are low.
- R2: A fresh command (`cmd_cont`=0) first issues sq=MM(base,R2), coded a=0, b=1, dst=1. It then issues acc=MM(R2,ONE), coded a=3, b=0, dst=0. No other multiplication comes before these two.
- R3: Exponent bits are taken lowest first. For a bit of 1, acc=MM(acc,sq) (a=1, b=2, dst=0) is issued before that bit's square sq=MM(sq,sq) (a=2, b=2, dst=1). A bit of 0 issues only the square.
- R4: On a word that is not last, all 64 bits are processed. The command issues popcount(word)+64 bit-loop multiplications and issues no exit multiplication.
- R5: On the last word, processing ends at the highest set bit, and that bit's square is omitted. The command then issues result=MM(acc,ONE) (a=1, b=0, dst=2). A zero last word issues only this exit step after any entry steps.
- R6: A continue command issues no entry steps and reuses the accumulator and square. A chain of words yields base^E mod M, where E is the concatenation of the words with the first command's word lowest.
- R7: `mm_start` is a one-cycle pulse. It is never raised while a multiplication is outstanding. The select codes do not change between a pulse and its `mm_done`.
- R8: `busy` rises in the cycle after an accepted `cmd_start`. `done` is a one-cycle pulse in the cycle where `busy` falls.
- R9: A `cmd_start` that arrives while `busy` is high has no effect on the operation sequence in progress.
- R10: After a last word, the result register holds base^E mod M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Command strobe, accepted when idle |
| cmd_cont | input | 1 | 1: continue from previous word; 0: fresh exponentiation |
| cmd_last | input | 1 | Marks the final exponent word |
| cmd_exp | input | EXP_W | Exponent word |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mm_start | output | 1 | Multiplication request pulse |
| mm_done | input | 1 | Multiplier completion pulse |
| mm_a_sel | output | 2 | First operand: 0 base, 1 acc, 2 sq, 3 R2 |
| mm_b_sel | output | 2 | Second operand: 0 one, 1 R2, 2 sq |
| mm_dst | output | 2 | Destination: 0 acc, 1 sq, 2 result |

## Verification
The hardest case to reach is a multi-word chain in which the accumulator and square must survive between commands. A flaw there shows up only in the final value, several hundred multiplications later. The bench drives chains of two and three words with dense and sparse bit patterns and compares the final value with a reference power computed with plain modular arithmetic. A stray command pulse is injected mid-run to probe the idle-only acceptance. The full trace of issued operation codes is compared against a trace rebuilt from the requirements, so a wrong order or a skipped square is caught even when the arithmetic happens to agree.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENT_SQ,
        ST_ENT_ACC,
        ST_PICK,
        ST_MUL,
        ST_SQR,
        ST_EXIT
    } seq_st_e;

    localparam logic [1:0] A_BASE = 2'd0;
    localparam logic [1:0] A_ACC  = 2'd1;
    localparam logic [1:0] A_SQ   = 2'd2;
    localparam logic [1:0] A_R2   = 2'd3;
    localparam logic [1:0] B_ONE  = 2'd0;
    localparam logic [1:0] B_R2   = 2'd1;
    localparam logic [1:0] B_SQ   = 2'd2;
    localparam logic [1:0] D_ACC  = 2'd0;
    localparam logic [1:0] D_SQ   = 2'd1;
    localparam logic [1:0] D_RES  = 2'd2;

    typedef struct packed {
        logic [1:0] a;
        logic [1:0] b;
        logic [1:0] d;
    } mm_op_t;

    typedef struct packed {
        seq_st_e    st;
        logic       pend;
        logic       last;
        logic       busy;
        logic       done;
        logic       go;
        mm_op_t     op;
    } ctl_t;

    function automatic mm_op_t op_for(seq_st_e s);
        mm_op_t o;
        case (s)
            ST_ENT_SQ:  o = '{a: A_BASE, b: B_R2,  d: D_SQ};
            ST_ENT_ACC: o = '{a: A_R2,   b: B_ONE, d: D_ACC};
            ST_MUL:     o = '{a: A_ACC,  b: B_SQ,  d: D_ACC};
            ST_SQR:     o = '{a: A_SQ,   b: B_SQ,  d: D_SQ};
            default:    o = '{a: A_ACC,  b: B_ONE, d: D_RES};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/modexp_expreg.sv
module modexp_expreg #(
    parameter int EXP_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [EXP_W-1:0] load_val,
    input  logic             shift,
    output logic             bit0,
    output logic             rest_zero,
    output logic             all_zero,
    output logic             cnt_zero
);
    localparam int CNT_W = $clog2(EXP_W + 1);

    typedef struct packed {
        logic [EXP_W-1:0] e;
        logic [CNT_W-1:0] n;
    } er_t;

    er_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.e = load_val;
            r_d.n = CNT_W'(EXP_W);
        end else if (shift) begin
            r_d.e = r_q.e >> 1;
            r_d.n = r_q.n - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bit0      = r_q.e[0];
    assign rest_zero = (r_q.e[EXP_W-1:1] == '0);
    assign all_zero  = (r_q.e == '0);
    assign cnt_zero  = (r_q.n == '0);
endmodule

// File: rtl/modexp_ctrl.sv
module modexp_ctrl
    import modexp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_start,
    input  logic       cmd_cont,
    input  logic       cmd_last,
    input  logic       mm_done,
    input  logic       bit0,
    input  logic       rest_zero,
    input  logic       all_zero,
    input  logic       cnt_zero,
    output logic       exp_load,
    output logic       exp_shift,
    output logic       busy,
    output logic       done,
    output logic       mm_start,
    output mm_op_t     mm_op
);
    ctl_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.go    = 1'b0;
        c_d.done  = 1'b0;
        exp_load  = 1'b0;
        exp_shift = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (cmd_start) begin
                    exp_load  = 1'b1;
                    c_d.busy  = 1'b1;
                    c_d.last  = cmd_last;
                    c_d.st    = cmd_cont ? ST_PICK : ST_ENT_SQ;
                end
            end
            ST_PICK: begin
                if (c_q.last ? all_zero : cnt_zero) begin
                    if (c_q.last) begin
                        c_d.st = ST_EXIT;
                    end else begin
                        c_d.st   = ST_IDLE;
                        c_d.busy = 1'b0;
                        c_d.done = 1'b1;
                    end
                end else begin
                    c_d.st = bit0 ? ST_MUL : ST_SQR;
                end
            end
            default: begin
                if (!c_q.pend) begin
                    c_d.go   = 1'b1;
                    c_d.pend = 1'b1;
                    c_d.op   = op_for(c_q.st);
                end else if (mm_done) begin
                    c_d.pend = 1'b0;
                    case (c_q.st)
                        ST_ENT_SQ:  c_d.st = ST_ENT_ACC;
                        ST_ENT_ACC: c_d.st = ST_PICK;
                        ST_MUL:     c_d.st = (c_q.last && rest_zero) ? ST_EXIT : ST_SQR;
                        ST_SQR: begin
                            exp_shift = 1'b1;
                            c_d.st    = ST_PICK;
                        end
                        default: begin
                            c_d.st   = ST_IDLE;
                            c_d.busy = 1'b0;
                            c_d.done = 1'b1;
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, pend: 1'b0, last: 1'b0, busy: 1'b0,
                     done: 1'b0, go: 1'b0, op: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign busy     = c_q.busy;
    assign done     = c_q.done;
    assign mm_start = c_q.go;
    assign mm_op    = c_q.op;
endmodule

// File: rtl/modexp_seq.sv
module modexp_seq
    import modexp_pkg::*;
#(
    parameter int EXP_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_cont,
    input  logic             cmd_last,
    input  logic [EXP_W-1:0] cmd_exp,
    output logic             busy,
    output logic             done,
    output logic             mm_start,
    input  logic             mm_done,
    output logic [1:0]       mm_a_sel,
    output logic [1:0]       mm_b_sel,
    output logic [1:0]       mm_dst
);
    logic   ld, sh, b0, rz, az, cz;
    mm_op_t op;

    modexp_expreg #(.EXP_W(EXP_W)) u_exp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .load_val  (cmd_exp),
        .shift     (sh),
        .bit0      (b0),
        .rest_zero (rz),
        .all_zero  (az),
        .cnt_zero  (cz)
    );

    modexp_ctrl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_cont  (cmd_cont),
        .cmd_last  (cmd_last),
        .mm_done   (mm_done),
        .bit0      (b0),
        .rest_zero (rz),
        .all_zero  (az),
        .cnt_zero  (cz),
        .exp_load  (ld),
        .exp_shift (sh),
        .busy      (busy),
        .done      (done),
        .mm_start  (mm_start),
        .mm_op     (op)
    );

    assign mm_a_sel = op.a;
    assign mm_b_sel = op.b;
    assign mm_dst   = op.d;
endmodule

// File: rtl/modexp_seq_chk.sv
module modexp_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       mm_start,
    input logic       mm_done,
    input logic [1:0] mm_a_sel,
    input logic [1:0] mm_b_sel,
    input logic [1:0] mm_dst
);
    logic outst_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        outst_q <= 1'b0;
        else if (mm_start) outst_q <= 1'b1;
        else if (mm_done)  outst_q <= 1'b0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) $fell(rst_n) |=> !busy && !done && !mm_start); // R1
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) mm_start |=> !mm_start); // R7
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) mm_start |-> !outst_q); // R7
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !mm_start |-> $stable({mm_a_sel, mm_b_sel, mm_dst})); // R7
    AST_ISSUE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mm_start |-> busy); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R8
    AST_EXIT_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n) (mm_start && mm_dst == 2'd2) |-> (mm_a_sel == 2'd1 && mm_b_sel == 2'd0)); // R5
endmodule

bind modexp_seq modexp_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .mm_start (mm_start),
    .mm_done  (mm_done),
    .mm_a_sel (mm_a_sel),
    .mm_b_sel (mm_b_sel),
    .mm_dst   (mm_dst)
);

// File: tb/tb_modexp_seq.sv
`timescale 1ns/1ps
module tb_modexp_seq;
    localparam int EXP_W = 64;
    localparam int LAT   = 3;
    localparam longint unsigned MOD = 64'hF123_4567;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0, cmd_cont = 1'b0, cmd_last = 1'b0;
    logic [EXP_W-1:0] cmd_exp = '0;
    logic busy, done, mm_start, mm_done;
    logic [1:0] mm_a_sel, mm_b_sel, mm_dst;

    always #10 clk = ~clk;

    modexp_seq #(.EXP_W(EXP_W)) dut (.*);

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input longint unsigned act, input longint unsigned exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint unsigned mont(longint unsigned a, longint unsigned b);
        longint unsigned t = 0;
        for (int i = 0; i < 32; i++) begin
            if (a[i]) t += b;
            if (t[0]) t += MOD;
            t >>= 1;
        end
        if (t >= MOD) t -= MOD;
        return t;
    endfunction

    // datapath model and multiplier stub
    longint unsigned base_v, r2_v, acc_r, sq_r, res_r, opa, opb;
    logic [1:0] dst_c;
    logic [5:0] op_c;
    logic s_busy = 1'b0;
    int s_cnt = 0;
    logic [5:0] act_ops[$];
    logic [5:0] exp_ops[$];

    function automatic longint unsigned pick_a(logic [1:0] s);
        case (s)
            2'd0: return mont(base_v, 1) == 0 ? base_v : base_v;
            2'd1: return acc_r;
            2'd2: return sq_r;
            default: return r2_v;
        endcase
    endfunction
    function automatic longint unsigned pick_b(logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return r2_v;
            default: return sq_r;
        endcase
    endfunction

    always @(posedge clk) begin
        mm_done <= 1'b0;
        if (!rst_n) begin
            s_busy <= 1'b0;
        end else if (mm_start) begin
            if (s_busy) chk(1'b0, "R7 start while outstanding", 1, 0);
            opa   <= pick_a(mm_a_sel);
            opb   <= pick_b(mm_b_sel);
            dst_c <= mm_dst;
            op_c  <= {mm_a_sel, mm_b_sel, mm_dst};
            act_ops.push_back({mm_a_sel, mm_b_sel, mm_dst});
            s_busy <= 1'b1;
            s_cnt  <= LAT;
        end else if (s_busy) begin
            if (s_cnt == 1) begin
                s_busy  <= 1'b0;
                mm_done <= 1'b1;
                case (dst_c)
                    2'd0: acc_r <= mont(opa, opb);
                    2'd1: sq_r  <= mont(opa, opb);
                    default: res_r <= mont(opa, opb);
                endcase
            end else begin
                s_cnt <= s_cnt - 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && s_busy && ({mm_a_sel, mm_b_sel, mm_dst} != op_c))
            chk(1'b0, "R7 selects moved", {mm_a_sel, mm_b_sel, mm_dst}, op_c);
    end

    // scoreboard
    typedef struct {
        longint unsigned res;
        bit has_res;
        string tag;
    } sb_item_t;
    sb_item_t sbq[$];

    always @(negedge clk) begin
        if (rst_n && done) begin
            sb_item_t it;
            chk(!busy, "R8 busy low at done", busy, 0);
            if (sbq.size() == 0) begin
                chk(1'b0, "R8 unexpected done", 1, 0);
            end else begin
                it = sbq.pop_front();
                chk(act_ops.size() == exp_ops.size(), {it.tag, " op count"}, act_ops.size(), exp_ops.size());
                if (act_ops.size() == exp_ops.size())
                    foreach (exp_ops[i])
                        chk(act_ops[i] == exp_ops[i], {it.tag, " op order"}, act_ops[i], exp_ops[i]);
                if (it.has_res) chk(res_r == it.res, "R10 result", res_r, it.res);
            end
            act_ops.delete();
            exp_ops.delete();
        end
    end

    longint unsigned ref_acc, ref_sq;

    task automatic drive(input longint unsigned b, input bit cont, input bit last,
                         input logic [EXP_W-1:0] w, input string tag, input bit poke);
        sb_item_t it;
        int hi = -1;
        if (!cont) begin
            base_v = b;
            ref_acc = 1;
            ref_sq = b % MOD;
            exp_ops.push_back(6'b00_01_01);
            exp_ops.push_back(6'b11_00_00);
        end
        for (int i = 0; i < EXP_W; i++) if (w[i]) hi = i;
        for (int i = 0; i < EXP_W; i++) begin
            if (last && i > hi) break;
            if (w[i]) begin
                ref_acc = (ref_acc * ref_sq) % MOD;
                exp_ops.push_back(6'b01_10_00);
            end
            if (!(last && i == hi)) exp_ops.push_back(6'b10_10_01);
            ref_sq = (ref_sq * ref_sq) % MOD;
        end
        if (last) exp_ops.push_back(6'b01_00_10);
        it.res = ref_acc;
        it.has_res = last;
        it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        cmd_cont = cont; cmd_last = last; cmd_exp = w; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        chk(busy, "R8 busy after start", busy, 1);
        if (poke) begin
            repeat (25) @(negedge clk);
            cmd_cont = 1'b0; cmd_last = 1'b1; cmd_exp = 64'h3; cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
            chk(busy, "R9 still busy after stray start", busy, 1);
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(!done, "R8 done one cycle", done, 0);
    endtask

    initial begin
        longint unsigned r1;
        r1 = (64'h1_0000_0000) % MOD;
        r2_v = (r1 * r1) % MOD;
        base_v = 0; acc_r = 0; sq_r = 0; res_r = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mm_start, "R1 reset outputs", {busy, done, mm_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mm_start, "R1 idle after reset", {busy, done, mm_start}, 0);

        drive(64'h1234_5678, 0, 1, 64'd5, "R2 R3 R5", 0);
        drive(64'h0BAD_F00D, 0, 1, 64'd0, "R5 zero word", 0);
        drive(64'h7777_1111, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R3 R5 dense", 0);
        drive(64'h0000_0002, 0, 1, 64'h8000_0000_0000_0001, "R5 sparse", 0);
        drive(64'hABCD_0123, 0, 0, 64'hDEAD_BEEF_0F0F_1357, "R4 first word", 0);
        drive(64'h0, 1, 1, 64'h0000_0000_0000_00C5, "R6 continue last", 0);
        drive(64'h5A5A_5A5A, 0, 0, 64'h0123_4567_89AB_CDEF, "R4 R9 word0", 1);
        drive(64'h0, 1, 0, 64'h0, "R4 R6 zero middle", 0);
        drive(64'h0, 1, 1, 64'h8000_0000_0000_0000, "R6 top word", 0);

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule